// File: doc/BRIEF.md
# Field Line-Count Classifier

This block watches a video timing stream and decides whether fields carry the 525-line or the 625-line standard. It counts line strobes between successive integrated vertical pulses. Each accepted length is matched against a range for each standard. One three-bit saturating vote counter per standard moves up on a match and down on a miss. The lock decision and the standard flag come from these votes, so one damaged field cannot flip the result.

Two status bits are produced. `std_locked_o` says that the votes have settled on one standard. `std_short_o` names that standard: 1 for 525-line, 0 for 625-line. When no lock is held, `std_short_o` falls back to a coarse split of the last accepted length at 287 lines. A window select chooses tight or loose ranges. Inputs and outputs are plain level or strobe pins with no handshake, because the block only samples timing events and holds state.

Top module: `field_std_classifier`

## Requirements
- R1: After reset, `std_locked_o` and `std_short_o` are both 0, and both vote counters are 0.
- R2: A field length is the number of cycles with `line_tick_i`=1 after the previous `vpulse_i` cycle, up to and including the current `vpulse_i` cycle. The first `vpulse_i` after reset only starts a count and is not a measurement.
- R3: With `narrow_win_i`=1, a length of 262 to 264 counts as 525-type, and a length of 312 to 314 counts as 625-type. Any other length matches neither.
- R4: With `narrow_win_i`=0, a length of 250 to 275 counts as 525-type, and a length of 300 to 325 counts as 625-type. The value of `narrow_win_i` is taken in the `vpulse_i` cycle.
- R5: Each accepted measurement moves both 3-bit vote counters. A counter steps up by 1 when the length matches its standard and steps down by 1 otherwise. Each counter saturates at 0 and 7.
- R6: `std_locked_o` becomes 1 when, after an update, either counter is 6 or more. It becomes 0 when both counters are 2 or less. Otherwise it holds its value.
- R7: While `std_locked_o`=1, `std_short_o` is 1 when the 525 counter is greater than the 625 counter, and 0 otherwise.
- R8: While `std_locked_o`=0, `std_short_o` is 1 if the last accepted length was below 287 lines and 0 if it was 287 or more. Before any accepted length it is 0.
- R9: A length above 400 lines is discarded. It leaves both counters, the last-length flag and both outputs unchanged, but its `vpulse_i` still restarts the count. A length of exactly 400 is accepted.
- R10: Outputs change only on the clock edge that ends a `vpulse_i` cycle, and they reflect that measurement from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick_i | input | 1 | One-cycle strobe per video line |
| vpulse_i | input | 1 | One-cycle strobe marking an integrated vertical pulse |
| narrow_win_i | input | 1 | 1 selects tight ranges, 0 selects loose ranges |
| std_locked_o | output | 1 | Votes have settled on one standard |
| std_short_o | output | 1 | 1 means 525-line type, 0 means 625-line type or long coarse length |

## Verification
The hardest state to reach is a lock that is held while the two counters cross each other. A run of 525-type fields saturates the 525 counter. Then 625-type fields are fed one at a time, so the stimulus passes through the point where lock is still held but `std_short_o` already names the other standard. Discarded over-long fields and lengths exactly at 286/287 and 400/401 are placed between the counted fields. A behavioural model compares both outputs on every clock.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_LONG  = 2'd2
  } field_cls_e;

  localparam int NUM_STD = 2;
  localparam int IDX_SHORT = 0;
  localparam int IDX_LONG  = 1;
endpackage

// File: rtl/fsc_line_meter.sv
module fsc_line_meter #(
  parameter int MAX_LINES = 400,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic             vpulse,
  output logic             meas_ok,
  output logic [CNT_W-1:0] meas_len
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LINES + 1);
  localparam logic [CNT_W-1:0] ACCEPT = CNT_W'(MAX_LINES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_now;
  logic             have_ref_q;

  assign len_now  = cnt_q + {{(CNT_W-1){1'b0}}, line_tick};
  assign meas_len = len_now;
  assign meas_ok  = vpulse && have_ref_q && (len_now <= ACCEPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (vpulse) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b1;
    end else if (len_now > LIMIT) begin
      cnt_q <= LIMIT;
    end else begin
      cnt_q <= len_now;
    end
  end
endmodule

// File: rtl/fsc_range_judge.sv
module fsc_range_judge
  import fsc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int SHORT_TIGHT_LO = 262,
  parameter int SHORT_TIGHT_HI = 264,
  parameter int LONG_TIGHT_LO = 312,
  parameter int LONG_TIGHT_HI = 314,
  parameter int SHORT_LOOSE_LO = 250,
  parameter int SHORT_LOOSE_HI = 275,
  parameter int LONG_LOOSE_LO = 300,
  parameter int LONG_LOOSE_HI = 325,
  parameter int MID_LINES = 287
) (
  input  logic [CNT_W-1:0] len,
  input  logic             narrow,
  output field_cls_e       cls,
  output logic             below_mid
);
  localparam logic [CNT_W-1:0] STL = CNT_W'(SHORT_TIGHT_LO);
  localparam logic [CNT_W-1:0] STH = CNT_W'(SHORT_TIGHT_HI);
  localparam logic [CNT_W-1:0] LTL = CNT_W'(LONG_TIGHT_LO);
  localparam logic [CNT_W-1:0] LTH = CNT_W'(LONG_TIGHT_HI);
  localparam logic [CNT_W-1:0] SLL = CNT_W'(SHORT_LOOSE_LO);
  localparam logic [CNT_W-1:0] SLH = CNT_W'(SHORT_LOOSE_HI);
  localparam logic [CNT_W-1:0] LLL = CNT_W'(LONG_LOOSE_LO);
  localparam logic [CNT_W-1:0] LLH = CNT_W'(LONG_LOOSE_HI);
  localparam logic [CNT_W-1:0] MID = CNT_W'(MID_LINES);

  logic [CNT_W-1:0] s_lo, s_hi, l_lo, l_hi;

  always_comb begin
    s_lo = narrow ? STL : SLL;
    s_hi = narrow ? STH : SLH;
    l_lo = narrow ? LTL : LLL;
    l_hi = narrow ? LTH : LLH;
    if (len >= s_lo && len <= s_hi)      cls = CLS_SHORT;
    else if (len >= l_lo && len <= l_hi) cls = CLS_LONG;
    else                                 cls = CLS_NONE;
  end

  assign below_mid = (len < MID);
endmodule

// File: rtl/fsc_vote_counter.sv
module fsc_vote_counter #(
  parameter int VOTE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              up,
  output logic [VOTE_W-1:0] cnt,
  output logic [VOTE_W-1:0] cnt_nxt
);
  localparam logic [VOTE_W-1:0] TOP = '1;

  always_comb begin
    cnt_nxt = cnt;
    if (step_en) begin
      if (up) cnt_nxt = (cnt == TOP) ? cnt : cnt + 1'b1;
      else    cnt_nxt = (cnt == '0)  ? cnt : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/field_std_classifier.sv
module field_std_classifier
  import fsc_pkg::*;
#(
  parameter int MAX_LINES = 400,
  parameter int MID_LINES = 287,
  parameter int VOTE_W = 3,
  parameter int SET_LVL = 6,
  parameter int CLR_LVL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick_i,
  input  logic vpulse_i,
  input  logic narrow_win_i,
  output logic std_locked_o,
  output logic std_short_o
);
  localparam int CNT_W = $clog2(MAX_LINES + 3);
  localparam logic [VOTE_W-1:0] SET_V = VOTE_W'(SET_LVL);
  localparam logic [VOTE_W-1:0] CLR_V = VOTE_W'(CLR_LVL);

  logic             meas_ok;
  logic [CNT_W-1:0] meas_len;
  field_cls_e       cls;
  logic             below_mid;
  logic             lock_q, below_q;

  logic [NUM_STD-1:0]  match;
  logic [VOTE_W-1:0]   vote_cur [NUM_STD];
  logic [VOTE_W-1:0]   vote_nxt [NUM_STD];
  logic [VOTE_W-1:0]   vote_short, vote_long;

  fsc_line_meter #(.MAX_LINES(MAX_LINES), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick_i), .vpulse(vpulse_i),
    .meas_ok(meas_ok), .meas_len(meas_len)
  );

  fsc_range_judge #(.CNT_W(CNT_W), .MID_LINES(MID_LINES)) u_judge (
    .len(meas_len), .narrow(narrow_win_i), .cls(cls), .below_mid(below_mid)
  );

  assign match[IDX_SHORT] = (cls == CLS_SHORT);
  assign match[IDX_LONG]  = (cls == CLS_LONG);

  for (genvar g = 0; g < NUM_STD; g++) begin : g_vote
    fsc_vote_counter #(.VOTE_W(VOTE_W)) u_vote (
      .clk(clk), .rst_n(rst_n), .step_en(meas_ok), .up(match[g]),
      .cnt(vote_cur[g]), .cnt_nxt(vote_nxt[g])
    );
  end

  assign vote_short = vote_cur[IDX_SHORT];
  assign vote_long  = vote_cur[IDX_LONG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      below_q <= 1'b0;
    end else if (meas_ok) begin
      below_q <= below_mid;
      if (vote_nxt[IDX_SHORT] >= SET_V || vote_nxt[IDX_LONG] >= SET_V)
        lock_q <= 1'b1;
      else if (vote_nxt[IDX_SHORT] <= CLR_V && vote_nxt[IDX_LONG] <= CLR_V)
        lock_q <= 1'b0;
    end
  end

  assign std_locked_o = lock_q;
  assign std_short_o  = lock_q ? (vote_short > vote_long) : below_q;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int VOTE_W = 3,
  parameter int SET_LVL = 6,
  parameter int CLR_LVL = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_ok,
  input logic              locked,
  input logic [VOTE_W-1:0] cnt_a,
  input logic [VOTE_W-1:0] cnt_b
);
  localparam logic [VOTE_W-1:0] SET_V = VOTE_W'(SET_LVL);
  localparam logic [VOTE_W-1:0] CLR_V = VOTE_W'(CLR_LVL);

  assert_hold_unmeasured_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ok |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(locked)));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ok |=> (({1'b0, cnt_a} == {1'b0, $past(cnt_a)} + 1'b1) ||
                 ({1'b0, cnt_a} + 1'b1 == {1'b0, $past(cnt_a)}) ||
                 (cnt_a == $past(cnt_a))));

  assert_no_double_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((cnt_a > $past(cnt_a)) && (cnt_b > $past(cnt_b))));

  assert_lock_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (cnt_a >= SET_V || cnt_b >= SET_V));

  assert_lock_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (cnt_a <= CLR_V && cnt_b <= CLR_V));
endmodule

bind field_std_classifier fsc_checker #(
  .VOTE_W(VOTE_W), .SET_LVL(SET_LVL), .CLR_LVL(CLR_LVL)
) u_fsc_chk (
  .clk(clk), .rst_n(rst_n), .meas_ok(meas_ok), .locked(std_locked_o),
  .cnt_a(vote_short), .cnt_b(vote_long)
);

// File: tb/tb_field_std_classifier.sv
module tb_field_std_classifier;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic vpulse = 1'b0;
  logic narrow = 1'b1;
  logic locked, short_o;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_have, m_a, m_b, m_lock, m_below;

  field_std_classifier dut (
    .clk(clk), .rst_n(rst_n), .line_tick_i(line_tick), .vpulse_i(vpulse),
    .narrow_win_i(narrow), .std_locked_o(locked), .std_short_o(short_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_have = 0; m_a = 0; m_b = 0; m_lock = 0; m_below = 0;
    end else begin
      int len;
      bit is_s, is_l;
      len = m_cnt + (line_tick ? 1 : 0);
      if (vpulse) begin
        if (m_have != 0 && len <= 400) begin
          is_s = narrow ? (len >= 262 && len <= 264) : (len >= 250 && len <= 275);
          is_l = narrow ? (len >= 312 && len <= 314) : (len >= 300 && len <= 325);
          m_a = is_s ? ((m_a < 7) ? m_a + 1 : 7) : ((m_a > 0) ? m_a - 1 : 0);
          m_b = is_l ? ((m_b < 7) ? m_b + 1 : 7) : ((m_b > 0) ? m_b - 1 : 0);
          if (m_a >= 6 || m_b >= 6) m_lock = 1;
          else if (m_a <= 2 && m_b <= 2) m_lock = 0;
          m_below = (len < 287) ? 1 : 0;
        end
        m_have = 1;
        m_cnt = 0;
      end else begin
        m_cnt = (len > 401) ? 401 : len;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      int eff;
      eff = (m_lock != 0) ? ((m_a > m_b) ? 1 : 0) : m_below;
      chk(locked == m_lock[0], "R6 per-cycle lock", int'(locked), m_lock);
      chk(short_o == eff[0], (m_lock != 0) ? "R7 per-cycle std" : "R8 per-cycle std",
          int'(short_o), eff);
    end
  end

  task automatic field(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      if (gap) begin
        @(negedge clk); line_tick = 1'b0; vpulse = 1'b0;
      end
      @(negedge clk); line_tick = 1'b1; vpulse = (i == n - 1);
    end
    @(negedge clk); line_tick = 1'b0; vpulse = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(locked == 1'b0 && short_o == 1'b0, "R1 reset outputs",
        int'({locked, short_o}), 0);
    rst_n = 1'b1;
  endtask

  task automatic expect_out(input int lk, input int st, input string tag);
    chk(locked == lk[0], tag, int'(locked), lk);
    chk(short_o == st[0], tag, int'(short_o), st);
  endtask

  initial begin
    do_reset();
    narrow = 1'b1;
    field(263, 0);
    expect_out(0, 0, "R2 first pulse is no measurement");
    field(263, 0);
    expect_out(0, 1, "R8 unlocked short length");
    for (int k = 0; k < 4; k++) field(263, 0);
    expect_out(0, 1, "R6 five votes not yet locked");
    // mid-field stability
    repeat (20) begin @(negedge clk); line_tick = 1'b1; end
    expect_out(0, 1, "R10 stable mid-field");
    line_tick = 1'b0;
    field(243, 0);   // completes 20+243 = 263
    expect_out(1, 1, "R3 R6 tight 525 lock");
    field(600, 0);
    expect_out(1, 1, "R9 long field discarded");
    field(263, 0);   // 525 counter -> 7
    field(313, 0); field(313, 0); field(313, 0);
    expect_out(1, 1, "R7 lock held 4 vs 3");
    field(313, 0);
    expect_out(1, 0, "R7 lock held 3 vs 4 flips std");
    field(313, 0); field(313, 0);
    expect_out(1, 0, "R3 tight 625 lock");
    field(132, 1);   // ticks on every other cycle, 132 ticks
    expect_out(1, 0, "R2 ticks not cycles");

    do_reset();
    narrow = 1'b0;
    field(255, 0);
    for (int k = 0; k < 6; k++) field(255, 0);
    expect_out(1, 1, "R4 loose 525 lock");
    narrow = 1'b1;
    for (int k = 0; k < 3; k++) field(255, 0);
    expect_out(1, 1, "R6 hold while 3 votes");
    field(255, 0);
    expect_out(0, 1, "R6 clear at two votes R8");
    field(287, 0);
    expect_out(0, 0, "R8 287 is long");
    field(286, 0);
    expect_out(0, 1, "R8 286 is short");
    field(401, 0);
    expect_out(0, 1, "R9 401 discarded");
    field(400, 0);
    expect_out(0, 0, "R9 400 accepted");
    narrow = 1'b0;
    for (int k = 0; k < 6; k++) field(325, 0);
    expect_out(1, 0, "R4 R5 loose 625 upper edge");
    for (int k = 0; k < 10; k++) field(300, 0);
    expect_out(1, 0, "R5 saturate at top");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule